// File: doc/BRIEF.md
# Branch and Skip Decision Unit

This block decides the next program counter for the conditional control-flow instructions of an 8-bit accumulator processor whose register pointers are 16 bits wide. For each accepted request it takes the opcode, a flag that marks the opcode as belonging to the extended page, the current pointer value, the operand bytes that follow the opcode, the processor flags (Q, DF, IE), the counter and external interrupt latches, four external flag lines, and the accumulator D. It then produces the resulting pointer value and, when a counter-interrupt branch is taken, a one-cycle pulse that clears the counter latch.

The pointer value given with a request (`pc_in`) is the address just past the opcode. There are three outcomes. A short branch replaces only the low byte of the pointer. A long branch loads all 16 bits from two operand bytes. A skip advances the pointer by one or two. Short branches report after 2 cycles; long branches, long skips and the two extended interrupt branches report after 3 cycles.

The controller is a four-state machine. `S_IDLE` accepts a request (transition *accept*, only for a recognised opcode). `S_OPND` is the first operand cycle: it goes to `S_DONE` for short branches (*short_end*) and to `S_OPND2` for everything else (*long_more*). `S_OPND2` goes to `S_DONE` (*long_end*). `S_DONE` shows the result and goes back to `S_IDLE` (*retire*).

Top module: `bbr_unit`

## Requirements
- R1: After reset `busy`, `done` and `ci_clear` are 0 and `pc_next` is 0x0000.
- R2: Short branch opcodes are 0x30–0x3F with `ext_page`=0. Bits [2:0] select the condition: 0 always, 1 Q, 2 D==0 (NOR of all eight bits of D), 3 DF, 4–7 EF lines 0–3. When the condition holds, `pc_next` = {`pc_in`[15:8], `opnd_a`}. Otherwise `pc_next` = `pc_in`+1 modulo 2^16.
- R3: For short opcodes, bit 3 inverts the selected condition. This makes 0x38 an unconditional one-byte skip.
- R4: Long branch opcodes are 0xC0–0xC3 (conditions always, Q, D==0, DF) and 0xC9–0xCB (Q=0, D!=0, DF=0). When taken, `pc_next` = {`opnd_a`, `opnd_b`}. Otherwise `pc_next` = `pc_in`+2 modulo 2^16.
- R5: Long skips add 2 to `pc_in` when their condition holds and otherwise leave it unchanged. The conditions are: 0xC5 Q=0, 0xC6 D!=0, 0xC7 DF=0, 0xCC IE=1, 0xCD Q=1, 0xCE D==0, 0xCF DF=1.
- R6: 0xC8 always yields `pc_in`+2, and 0xC4 always yields `pc_in`.
- R7: With `ext_page`=1, opcode 0x3E branches like a short branch when `latch_ci`=1 and then pulses `ci_clear` for exactly the `done` cycle. Opcode 0x3F tests `latch_xi` and never pulses `ci_clear`.
- R8: `done` rises 2 cycles after the accepting edge's request for short branches and 3 for all others. It lasts one cycle. `busy` is high from the cycle after acceptance through the `done` cycle.
- R9: A `start` while `busy` is high is ignored. So is a `start` with an opcode outside the sets above, including extended-page opcodes other than 0x3E/0x3F.
- R10: `pc_next` holds its value while `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| ext_page | input | 1 | Opcode is from the extended page |
| opcode | input | 8 | Instruction opcode |
| pc_in | input | 16 | Pointer value just past the opcode |
| opnd_a | input | 8 | First operand byte |
| opnd_b | input | 8 | Second operand byte |
| flag_q | input | 1 | Q flag |
| flag_df | input | 1 | DF flag |
| flag_ie | input | 1 | Interrupt enable |
| latch_ci | input | 1 | Counter interrupt latch |
| latch_xi | input | 1 | External interrupt latch |
| ef_in | input | 4 | External flag lines 1–4 (bit 0 = line 1) |
| acc_d | input | 8 | Accumulator D |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid strobe |
| pc_next | output | 16 | Resulting pointer value |
| ci_clear | output | 1 | Counter latch clear pulse |

## Verification
The hardest situations to reach are the ones where the pointer wraps or changes only partly. A short not-taken branch at 0x12FF must carry into the high byte. A long not-taken branch at 0xFFFF must wrap to 0x0001. A taken short branch must keep the high byte. The vector table places the request pointer at exactly these addresses. The D==0 test uses a D value with only the top bit set, so a partial zero detect would show up. A second `start` is placed in the cycle after acceptance to show that a busy unit drops it.

// File: rtl/bbr_pkg.sv
package bbr_pkg;
    typedef enum logic [2:0] {
        K_NONE,
        K_SHORT,
        K_LONG,
        K_SKIP,
        K_INTB
    } kind_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_OPND,
        S_OPND2,
        S_DONE
    } state_t;
endpackage

// File: rtl/bbr_decode.sv
module bbr_decode
    import bbr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          ext_page,
    input  logic [7:0]    opcode,
    input  logic          flag_q,
    input  logic          flag_df,
    input  logic          flag_ie,
    input  logic          latch_ci,
    input  logic          latch_xi,
    input  logic [3:0]    ef_in,
    input  logic [DW-1:0] acc_d,
    output kind_t         kind,
    output logic          taken
);
    logic d_zero;
    logic base;
    logic lbase;

    assign d_zero = ~|acc_d;

    // condition selected by the low three opcode bits
    always_comb begin
        unique case (opcode[2:0])
            3'd0:    base = 1'b1;
            3'd1:    base = flag_q;
            3'd2:    base = d_zero;
            3'd3:    base = flag_df;
            default: base = ef_in[opcode[1:0]];
        endcase
    end

    always_comb begin
        unique case (opcode[1:0])
            2'd0:    lbase = 1'b1;
            2'd1:    lbase = flag_q;
            2'd2:    lbase = d_zero;
            default: lbase = flag_df;
        endcase
    end

    always_comb begin
        kind  = K_NONE;
        taken = 1'b0;
        if (ext_page) begin
            if (opcode == 8'h3E) begin
                kind  = K_INTB;
                taken = latch_ci;
            end else if (opcode == 8'h3F) begin
                kind  = K_INTB;
                taken = latch_xi;
            end
        end else if (opcode[7:4] == 4'h3) begin
            kind  = K_SHORT;
            taken = base ^ opcode[3];
        end else if (opcode[7:4] == 4'hC) begin
            unique case (opcode[3:0])
                4'h0, 4'h1, 4'h2, 4'h3: begin kind = K_LONG; taken = lbase;    end
                4'h9, 4'hA, 4'hB:       begin kind = K_LONG; taken = ~lbase;   end
                4'h4:                   begin kind = K_SKIP; taken = 1'b0;     end
                4'h5:                   begin kind = K_SKIP; taken = ~flag_q;  end
                4'h6:                   begin kind = K_SKIP; taken = ~d_zero;  end
                4'h7:                   begin kind = K_SKIP; taken = ~flag_df; end
                4'h8:                   begin kind = K_SKIP; taken = 1'b1;     end
                4'hC:                   begin kind = K_SKIP; taken = flag_ie;  end
                4'hD:                   begin kind = K_SKIP; taken = flag_q;   end
                4'hE:                   begin kind = K_SKIP; taken = d_zero;   end
                default:                begin kind = K_SKIP; taken = flag_df;  end
            endcase
        end
    end
endmodule

// File: rtl/bbr_target.sv
module bbr_target
    import bbr_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  kind_t         kind,
    input  logic          taken,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic [AW-1:0] pc_out
);
    logic [AW-1:0] inc1;
    logic [AW-1:0] inc2;

    assign inc1 = pc_in + AW'(1);
    assign inc2 = pc_in + AW'(2);

    always_comb begin
        unique case (kind)
            K_SHORT, K_INTB: pc_out = taken ? {pc_in[AW-1:DW], opnd_a} : inc1;
            K_LONG:          pc_out = taken ? {opnd_a, opnd_b} : inc2;
            K_SKIP:          pc_out = taken ? inc2 : pc_in;
            default:         pc_out = pc_in;
        endcase
    end
endmodule

// File: rtl/bbr_unit.sv
module bbr_unit
    import bbr_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          ext_page,
    input  logic [7:0]    opcode,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic          flag_q,
    input  logic          flag_df,
    input  logic          flag_ie,
    input  logic          latch_ci,
    input  logic          latch_xi,
    input  logic [3:0]    ef_in,
    input  logic [DW-1:0] acc_d,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] pc_next,
    output logic          ci_clear
);
    kind_t         kind_w;
    kind_t         kind_q;
    logic          taken_w;
    logic [AW-1:0] pc_w;
    logic [AW-1:0] pc_q;
    logic          clr_q;
    logic          accept;
    state_t        state_q;
    state_t        state_d;

    bbr_decode #(.DW(DW)) u_dec (
        .ext_page (ext_page),
        .opcode   (opcode),
        .flag_q   (flag_q),
        .flag_df  (flag_df),
        .flag_ie  (flag_ie),
        .latch_ci (latch_ci),
        .latch_xi (latch_xi),
        .ef_in    (ef_in),
        .acc_d    (acc_d),
        .kind     (kind_w),
        .taken    (taken_w)
    );

    bbr_target #(.DW(DW)) u_tgt (
        .kind   (kind_w),
        .taken  (taken_w),
        .pc_in  (pc_in),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .pc_out (pc_w)
    );

    assign accept = (state_q == S_IDLE) && start && (kind_w != K_NONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_OPND;
            S_OPND:  state_d = (kind_q == K_SHORT) ? S_DONE : S_OPND2;
            S_OPND2: state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_NONE;
            pc_q    <= '0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                kind_q <= kind_w;
                pc_q   <= pc_w;
                clr_q  <= (kind_w == K_INTB) && (opcode == 8'h3E) && taken_w;
            end
        end
    end

    always_comb begin
        busy     = (state_q != S_IDLE);
        done     = (state_q == S_DONE);
        ci_clear = (state_q == S_DONE) && clr_q;
        pc_next  = pc_q;
    end
endmodule

// File: rtl/bbr_checker.sv
module bbr_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] pc_next,
    input logic          ci_clear
);
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R8
    retire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R7
    clr_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ci_clear |-> done);

    // R10
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pc_next));
endmodule

bind bbr_unit bbr_checker #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .pc_next  (pc_next),
    .ci_clear (ci_clear)
);

// File: tb/bbr_unit_bench.sv
module bbr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        ext_page = 1'b0;
    logic [7:0]  opcode = 8'h00;
    logic [15:0] pc_in = 16'h0;
    logic [7:0]  opnd_a = 8'h0;
    logic [7:0]  opnd_b = 8'h0;
    logic        flag_q = 1'b0;
    logic        flag_df = 1'b0;
    logic        flag_ie = 1'b0;
    logic        latch_ci = 1'b0;
    logic        latch_xi = 1'b0;
    logic [3:0]  ef_in = 4'h0;
    logic [7:0]  acc_d = 8'h0;
    logic        busy;
    logic        done;
    logic [15:0] pc_next;
    logic        ci_clear;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    bbr_unit u_bbr_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .ext_page(ext_page),
        .opcode(opcode), .pc_in(pc_in), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .flag_q(flag_q), .flag_df(flag_df), .flag_ie(flag_ie),
        .latch_ci(latch_ci), .latch_xi(latch_xi), .ef_in(ef_in),
        .acc_d(acc_d), .busy(busy), .done(done), .pc_next(pc_next),
        .ci_clear(ci_clear)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        ext;
        logic [7:0]  op;
        logic        q;
        logic        df;
        logic        ie;
        logic        ci;
        logic        xi;
        logic [3:0]  ef;
        logic [7:0]  d;
        logic [15:0] pc;
        logic [15:0] epc;
        logic [2:0]  ecyc;
        logic        eclr;
    } vec_t;

    localparam int NV = 31;
    // operand bytes are fixed at 0x56 / 0x78 for every vector
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b0, 8'h30, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1256, 3'd2, 1'b0}, // R2 always
        '{4'd2, 1'b0, 8'h31, 1'b1,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1256, 3'd2, 1'b0}, // R2 Q=1
        '{4'd2, 1'b0, 8'h31, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1235, 3'd2, 1'b0}, // R2 Q=0
        '{4'd2, 1'b0, 8'h32, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h00, 16'h1234, 16'h1256, 3'd2, 1'b0}, // R2 D==0
        '{4'd2, 1'b0, 8'h32, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h80, 16'h1234, 16'h1235, 3'd2, 1'b0}, // R2 D msb only
        '{4'd3, 1'b0, 8'h3A, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h00, 16'h1234, 16'h1235, 3'd2, 1'b0}, // R3 D!=0 false
        '{4'd3, 1'b0, 8'h3A, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h80, 16'h1234, 16'h1256, 3'd2, 1'b0}, // R3 D!=0 true
        '{4'd2, 1'b0, 8'h33, 1'b0,1'b1,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1256, 3'd2, 1'b0}, // R2 DF
        '{4'd3, 1'b0, 8'h3B, 1'b0,1'b1,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1235, 3'd2, 1'b0}, // R3 DF=0 false
        '{4'd2, 1'b0, 8'h34, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h1, 8'h01, 16'h1234, 16'h1256, 3'd2, 1'b0}, // R2 EF1
        '{4'd2, 1'b0, 8'h37, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h7, 8'h01, 16'h1234, 16'h1235, 3'd2, 1'b0}, // R2 EF4 low
        '{4'd3, 1'b0, 8'h3F, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1256, 3'd2, 1'b0}, // R3 EF4=0
        '{4'd3, 1'b0, 8'h3C, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h1, 8'h01, 16'h1234, 16'h1235, 3'd2, 1'b0}, // R3 EF1=0 false
        '{4'd3, 1'b0, 8'h38, 1'b1,1'b1,1'b1,1'b0,1'b0, 4'hF, 8'h00, 16'h1234, 16'h1235, 3'd2, 1'b0}, // R3 skip one
        '{4'd2, 1'b0, 8'h38, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h12FF, 16'h1300, 3'd2, 1'b0}, // R2 carry
        '{4'd4, 1'b0, 8'hC0, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h5678, 3'd3, 1'b0}, // R4 always
        '{4'd4, 1'b0, 8'hC1, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1236, 3'd3, 1'b0}, // R4 Q=0
        '{4'd4, 1'b0, 8'hCB, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h5678, 3'd3, 1'b0}, // R4 DF=0
        '{4'd4, 1'b0, 8'hC2, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'hFFFF, 16'h0001, 3'd3, 1'b0}, // R4 wrap
        '{4'd4, 1'b0, 8'hCA, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h40, 16'h1234, 16'h5678, 3'd3, 1'b0}, // R4 D!=0
        '{4'd6, 1'b0, 8'hC4, 1'b1,1'b1,1'b1,1'b1,1'b1, 4'hF, 8'h00, 16'h1234, 16'h1234, 3'd3, 1'b0}, // R6 nop
        '{4'd6, 1'b0, 8'hC8, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1236, 3'd3, 1'b0}, // R6 skip two
        '{4'd5, 1'b0, 8'hC5, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1236, 3'd3, 1'b0}, // R5 Q=0
        '{4'd5, 1'b0, 8'hCD, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1234, 3'd3, 1'b0}, // R5 Q=1 false
        '{4'd5, 1'b0, 8'hCC, 1'b0,1'b0,1'b1,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1236, 3'd3, 1'b0}, // R5 IE
        '{4'd5, 1'b0, 8'hCE, 1'b0,1'b0,1'b0,1'b0,1'b0, 4'h0, 8'h00, 16'h1234, 16'h1236, 3'd3, 1'b0}, // R5 D==0
        '{4'd5, 1'b0, 8'hC7, 1'b0,1'b1,1'b0,1'b0,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1234, 3'd3, 1'b0}, // R5 DF=0 false
        '{4'd7, 1'b1, 8'h3E, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1256, 3'd3, 1'b1}, // R7 CI set
        '{4'd7, 1'b1, 8'h3E, 1'b0,1'b0,1'b0,1'b0,1'b1, 4'h0, 8'h01, 16'h1234, 16'h1235, 3'd3, 1'b0}, // R7 CI clear
        '{4'd7, 1'b1, 8'h3F, 1'b0,1'b0,1'b0,1'b1,1'b1, 4'h0, 8'h01, 16'h1234, 16'h1256, 3'd3, 1'b0}, // R7 XI set
        '{4'd7, 1'b1, 8'h3F, 1'b0,1'b0,1'b0,1'b1,1'b0, 4'h0, 8'h01, 16'h1234, 16'h1235, 3'd3, 1'b0}  // R7 XI clear
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // waits for done; returns cycles seen, pc and whether ci_clear pulsed
    task automatic wait_done(output int cyc, output logic [15:0] pc, output logic clr);
        cyc = 0; pc = 16'h0; clr = 1'b0;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            start = 1'b0;
            if (ci_clear) clr = 1'b1;
            if (done) begin
                cyc = k; pc = pc_next;
                break;
            end
        end
    endtask

    initial begin
        #(5ns * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int          cyc;
        logic [15:0] pc;
        logic        clr;
        logic        seen;
        opnd_a = 8'h56; opnd_b = 8'h78;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 ci_clear", 32'(ci_clear), 32'd0);
        check("R1 pc_next", 32'(pc_next), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            ext_page = VECS[i].ext; opcode = VECS[i].op;
            flag_q = VECS[i].q; flag_df = VECS[i].df; flag_ie = VECS[i].ie;
            latch_ci = VECS[i].ci; latch_xi = VECS[i].xi;
            ef_in = VECS[i].ef; acc_d = VECS[i].d; pc_in = VECS[i].pc;
            start = 1'b1;
            wait_done(cyc, pc, clr);
            check($sformatf("R%0d vec%0d pc", VECS[i].req, i), 32'(pc), 32'(VECS[i].epc));
            // R8 latency per class
            check($sformatf("R8 vec%0d cycles", i), 32'(cyc), 32'(VECS[i].ecyc));
            check($sformatf("R7 vec%0d ci_clear", i), 32'(clr), 32'(VECS[i].eclr));
            @(negedge clk);
            check($sformatf("R8 vec%0d idle after", i), 32'(busy), 32'd0);
        end

        // R9 start while busy ignored
        ext_page = 1'b0; opcode = 8'h30; pc_in = 16'hAB10;
        start = 1'b1;
        @(negedge clk);
        check("R9 busy after accept", 32'(busy), 32'd1);
        opcode = 8'hC0; pc_in = 16'h0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9 first done", 32'(done), 32'd1);
        check("R9 first pc kept", 32'(pc_next), 32'hAB56);
        seen = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            if (done || busy) seen = 1'b1;
        end
        check("R9 second request dropped", 32'(seen), 32'd0);
        check("R10 pc after drop", 32'(pc_next), 32'hAB56);

        // R9 unhandled opcodes ignored
        opcode = 8'h00; ext_page = 1'b0; start = 1'b1;
        @(negedge clk);
        check("R9 opcode 00 ignored", 32'(busy), 32'd0);
        opcode = 8'h30; ext_page = 1'b1;
        @(negedge clk);
        check("R9 ext 30 ignored", 32'(busy), 32'd0);
        opcode = 8'hD4; ext_page = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check("R9 opcode D4 ignored", 32'(busy), 32'd0);
        check("R9 pc unchanged", 32'(pc_next), 32'hAB56);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule